// File: doc/BRIEF.md
# Accumulator ALU with status flags

This block is the 8-bit arithmetic unit of a small accumulator-based processor datapath. It takes the accumulator byte and a second operand. The second operand comes from a register, from the memory byte, or from an immediate byte in the instruction. The block computes one of six arithmetic operations: add, add with carry, subtract, subtract with borrow, increment and decrement. The stored carry flag feeds the carry-in port. The same carry flag serves as the borrow for subtract-with-borrow.

Each result comes with five status flags: sign, zero, auxiliary carry, parity and carry. An update mask goes with them. The mask tells the flag register which of the five flags the operation is allowed to write, so increment and decrement leave the stored carry alone. The result, flags and mask are registered, with one cycle of latency from the inputs to the outputs. Storage of the flag register belongs to the surrounding logic.

Top module: `aalu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `res_o`=0x00, `flags_o`=5'b01010 and `upd_o`=5'b00000 on that edge.
- R2: Outputs are registered. The values visible after a rising edge depend only on the inputs sampled at that edge, so a change of inputs between edges does not reach the outputs before the next edge.
- R3: Op code 0 (add) gives acc + operand and ignores `cy_i`. Op code 1 (add with carry) gives acc + operand + `cy_i`. For both, the carry flag is the carry out of bit 7.
- R4: Op code 2 (subtract) gives acc − operand. Op code 3 (subtract with borrow) gives acc − operand − `cy_i`. For both, the carry flag is 1 exactly when the true difference is negative (a borrow).
- R5: The auxiliary carry flag is the carry from bit 3 into bit 4 for additions and increment. For subtractions and decrement, it is the borrow into bit 3 from bit 4, that is, the low-nibble difference is negative.
- R6: The `flags_o` bit positions are [4] sign, [3] zero, [2] auxiliary carry, [1] parity and [0] carry. Sign equals result bit 7. Zero is 1 when the result is 0x00. Parity is 1 when the result has an even number of one bits.
- R7: Op code 4 (increment) and op code 5 (decrement) change the selected operand (not the accumulator) by exactly one, wrapping modulo 256. Their carry output repeats `cy_i`, and their `upd_o` is 5'b11110.
- R8: For op codes 0 to 3, `upd_o` is 5'b11111. The bit positions of `upd_o` match those of `flags_o`.
- R9: `src_sel_i` picks the second operand: 0 register byte, 1 memory byte, 2 immediate byte, 3 register byte. The two inputs that are not selected have no effect on any output.
- R10: Op codes 6 and 7 are reserved. They return the accumulator unchanged in `res_o`, with `upd_o`=5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation code (see R3, R4, R7, R10) |
| src_sel_i | input | 2 | Second-operand source select |
| acc_i | input | 8 | Accumulator operand |
| reg_i | input | 8 | Register-file operand byte |
| mem_i | input | 8 | Memory operand byte |
| imm_i | input | 8 | Immediate operand byte |
| cy_i | input | 1 | Stored carry flag, used as carry-in or borrow-in |
| res_o | output | 8 | Registered result |
| flags_o | output | 5 | Registered flags {S, Z, AC, P, CY} |
| upd_o | output | 5 | Registered per-flag write enables, same bit order |

## Verification
The checker watches on every cycle that sign, zero and parity agree with the registered result, and that the reset values appear. It also checks that the update mask matches the previous cycle's op class, that increment and decrement pass the incoming carry through, and that reserved codes return the accumulator. The arithmetic itself cannot be checked by a property that stays independent of the RTL: the sums, the borrow sense of carry and auxiliary carry, the wrap of increment and decrement at 0xFF and 0x00, and the independence from unselected sources. The bench's sweeps show these, with add-with-carry and subtract-with-borrow swept across the whole accumulator range and both carry-in values.

// File: rtl/aalu_pkg.sv
package aalu_pkg;

  localparam int NFLAG = 5;

  // flag / update-mask bit positions
  localparam int FL_S  = 4;
  localparam int FL_Z  = 3;
  localparam int FL_AC = 2;
  localparam int FL_P  = 1;
  localparam int FL_CY = 0;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_REG  = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_REG2 = 2'd3
  } alu_src_e;

  localparam logic [NFLAG-1:0] UPD_ALL  = 5'b11111;
  localparam logic [NFLAG-1:0] UPD_STEP = 5'b11110;
  localparam logic [NFLAG-1:0] UPD_NONE = 5'b00000;

endpackage

// File: rtl/aalu_src_mux.sv
module aalu_src_mux #(
  parameter int DW = 8
) (
  input  aalu_pkg::alu_src_e sel_i,
  input  logic [DW-1:0]      reg_i,
  input  logic [DW-1:0]      mem_i,
  input  logic [DW-1:0]      imm_i,
  output logic [DW-1:0]      opnd_o
);
  import aalu_pkg::*;

  always_comb begin
    unique case (sel_i)
      SRC_MEM: opnd_o = mem_i;
      SRC_IMM: opnd_o = imm_i;
      default: opnd_o = reg_i;
    endcase
  end

endmodule

// File: rtl/aalu_op_decode.sv
module aalu_op_decode #(
  parameter int DW = 8
) (
  input  aalu_pkg::alu_op_e          op_i,
  input  logic [DW-1:0]              acc_i,
  input  logic [DW-1:0]              opnd_i,
  input  logic                       cy_i,
  output logic [DW-1:0]              x_o,
  output logic [DW-1:0]              y_o,
  output logic                       cin_o,
  output logic                       sub_o,
  output logic                       pass_o,
  output logic                       keep_cy_o,
  output logic [aalu_pkg::NFLAG-1:0] upd_o
);
  import aalu_pkg::*;

  localparam logic [DW-1:0] ZERO_W  = '0;
  localparam logic [DW-1:0] MINUS_1 = {{(DW-1){1'b1}}, 1'b0}; // ~1

  always_comb begin
    x_o       = acc_i;
    y_o       = opnd_i;
    cin_o     = 1'b0;
    sub_o     = 1'b0;
    pass_o    = 1'b0;
    keep_cy_o = 1'b0;
    upd_o     = UPD_ALL;
    unique case (op_i)
      OP_ADD: ;
      OP_ADC: cin_o = cy_i;
      OP_SUB: begin
        y_o   = ~opnd_i;
        cin_o = 1'b1;
        sub_o = 1'b1;
      end
      OP_SBB: begin
        y_o   = ~opnd_i;
        cin_o = ~cy_i;
        sub_o = 1'b1;
      end
      OP_INC: begin
        x_o       = opnd_i;
        y_o       = ZERO_W;
        cin_o     = 1'b1;
        keep_cy_o = 1'b1;
        upd_o     = UPD_STEP;
      end
      OP_DEC: begin
        x_o       = opnd_i;
        y_o       = MINUS_1;
        cin_o     = 1'b1;
        sub_o     = 1'b1;
        keep_cy_o = 1'b1;
        upd_o     = UPD_STEP;
      end
      default: begin
        pass_o    = 1'b1;
        keep_cy_o = 1'b1;
        upd_o     = UPD_NONE;
      end
    endcase
  end

endmodule

// File: rtl/aalu_nibble_adder.sv
module aalu_nibble_adder #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o,
  output logic          cy_o,
  output logic          ac_o
);
  localparam int HW = DW - NIB;

  logic [NIB:0] lo;
  logic [HW:0]  hi;

  always_comb begin
    lo = {1'b0, x_i[NIB-1:0]} + {1'b0, y_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
    hi = {1'b0, x_i[DW-1:NIB]} + {1'b0, y_i[DW-1:NIB]} + {{HW{1'b0}}, lo[NIB]};
    sum_o = {hi[HW-1:0], lo[NIB-1:0]};
    // subtract path: a missing carry means a borrow happened
    cy_o  = sub_i ? ~hi[HW]  : hi[HW];
    ac_o  = sub_i ? ~lo[NIB] : lo[NIB];
  end

endmodule

// File: rtl/aalu_flag_gen.sv
module aalu_flag_gen #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]              res_i,
  input  logic                       cy_i,
  input  logic                       ac_i,
  output logic [aalu_pkg::NFLAG-1:0] flags_o
);
  import aalu_pkg::*;

  always_comb begin
    flags_o        = '0;
    flags_o[FL_S]  = res_i[DW-1];
    flags_o[FL_Z]  = (res_i == '0);
    flags_o[FL_AC] = ac_i;
    flags_o[FL_P]  = ~(^res_i);
    flags_o[FL_CY] = cy_i;
  end

endmodule

// File: rtl/aalu_core.sv
module aalu_core #(
  parameter int DW  = 8,
  parameter int NIB = DW / 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 op_i,
  input  logic [1:0]                 src_sel_i,
  input  logic [DW-1:0]              acc_i,
  input  logic [DW-1:0]              reg_i,
  input  logic [DW-1:0]              mem_i,
  input  logic [DW-1:0]              imm_i,
  input  logic                       cy_i,
  output logic [DW-1:0]              res_o,
  output logic [aalu_pkg::NFLAG-1:0] flags_o,
  output logic [aalu_pkg::NFLAG-1:0] upd_o
);
  import aalu_pkg::*;

  localparam logic [NFLAG-1:0] FLAGS_RST = 5'b01010; // Z=1, P=1 for a zero result

  logic [DW-1:0]    opnd, x, y, sum, res_d;
  logic             cin, sub, pass, keep_cy, add_cy, add_ac, cy_d, ac_d;
  logic [NFLAG-1:0] upd_d, flags_d;

  aalu_src_mux #(.DW(DW)) u_src (
    .sel_i  (alu_src_e'(src_sel_i)),
    .reg_i  (reg_i),
    .mem_i  (mem_i),
    .imm_i  (imm_i),
    .opnd_o (opnd)
  );

  aalu_op_decode #(.DW(DW)) u_dec (
    .op_i      (alu_op_e'(op_i)),
    .acc_i     (acc_i),
    .opnd_i    (opnd),
    .cy_i      (cy_i),
    .x_o       (x),
    .y_o       (y),
    .cin_o     (cin),
    .sub_o     (sub),
    .pass_o    (pass),
    .keep_cy_o (keep_cy),
    .upd_o     (upd_d)
  );

  aalu_nibble_adder #(.DW(DW), .NIB(NIB)) u_add (
    .x_i   (x),
    .y_i   (y),
    .cin_i (cin),
    .sub_i (sub),
    .sum_o (sum),
    .cy_o  (add_cy),
    .ac_o  (add_ac)
  );

  always_comb begin
    res_d = pass ? acc_i : sum;
    ac_d  = pass ? 1'b0  : add_ac;
    cy_d  = keep_cy ? cy_i : add_cy;
  end

  aalu_flag_gen #(.DW(DW)) u_flg (
    .res_i   (res_d),
    .cy_i    (cy_d),
    .ac_i    (ac_d),
    .flags_o (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      flags_o <= FLAGS_RST;
      upd_o   <= UPD_NONE;
    end else begin
      res_o   <= res_d;
      flags_o <= flags_d;
      upd_o   <= upd_d;
    end
  end

endmodule

// File: rtl/aalu_core_chk.sv
module aalu_core_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic          cy_i,
  input logic [DW-1:0] res_o,
  input logic [4:0]    flags_o,
  input logic [4:0]    upd_o
);

  AST_RESET_VALUES: assert property (@(posedge clk)
    $past(rst) |-> (res_o == '0 && flags_o == 5'b01010 && upd_o == 5'b00000)); // R1

  AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
    flags_o[4] == res_o[DW-1]); // R6

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    flags_o[3] == (res_o == '0)); // R6

  AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    flags_o[1] == ($countones(res_o) % 2 == 0)); // R6

  AST_ARITH_MASK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) < 3'd4) |-> upd_o == 5'b11111); // R8

  AST_STEP_KEEPS_CY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_i) == 3'd4 || $past(op_i) == 3'd5))
      |-> (upd_o == 5'b11110 && flags_o[0] == $past(cy_i))); // R7

  AST_RSV_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_i) >= 3'd6)
      |-> (upd_o == 5'b00000 && res_o == $past(acc_i))); // R10

endmodule

bind aalu_core aalu_core_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_i    (op_i),
  .acc_i   (acc_i),
  .cy_i    (cy_i),
  .res_o   (res_o),
  .flags_o (flags_o),
  .upd_o   (upd_o)
);

// File: tb/aalu_core_bench.sv
module aalu_core_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op_i = '0;
  logic [1:0] src_sel_i = '0;
  logic [7:0] acc_i = '0, reg_i = '0, mem_i = '0, imm_i = '0;
  logic       cy_i = 1'b0;
  logic [7:0] res_o;
  logic [4:0] flags_o, upd_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  aalu_core u_aalu_core (
    .clk(clk), .rst(rst), .op_i(op_i), .src_sel_i(src_sel_i),
    .acc_i(acc_i), .reg_i(reg_i), .mem_i(mem_i), .imm_i(imm_i),
    .cy_i(cy_i), .res_o(res_o), .flags_o(flags_o), .upd_o(upd_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (op %0d a %0h b %0h c %0d)",
               tag, act, exp, op_i, acc_i, reg_i, cy_i);
    end
  endtask

  // expected {res[7:0], flags[4:0], mask[4:0]} from the requirement text
  function automatic logic [17:0] model(int op, int a, int b, int c);
    int r, cy, ac;
    logic [4:0] m;
    logic [7:0] rb;
    case (op)
      0: begin r = a + b;     cy = int'(r > 255); ac = int'((a%16)+(b%16) > 15);     m = 5'b11111; end
      1: begin r = a + b + c; cy = int'(r > 255); ac = int'((a%16)+(b%16)+c > 15);   m = 5'b11111; end
      2: begin r = a - b;     cy = int'(a < b);   ac = int'((a%16) < (b%16));        m = 5'b11111; end
      3: begin r = a - b - c; cy = int'(a < b+c); ac = int'((a%16) < (b%16)+c);      m = 5'b11111; end
      4: begin r = b + 1;     cy = c;             ac = int'(b%16 == 15);             m = 5'b11110; end
      5: begin r = b - 1;     cy = c;             ac = int'(b%16 == 0);              m = 5'b11110; end
      default: begin r = a;   cy = c;             ac = 0;                            m = 5'b00000; end
    endcase
    rb = r[7:0];
    return {rb, rb[7], rb == 8'h00, ac[0], ~(^rb), cy[0], m};
  endfunction

  // drive one vector at a falling edge, check it one falling edge later
  task automatic vec(int op, int sel, int a, int b, int c, string tag);
    logic [17:0] e;
    op_i      = op[2:0];
    src_sel_i = sel[1:0];
    acc_i     = a[7:0];
    cy_i      = c[0];
    reg_i = 8'(b ^ 8'h5a); mem_i = 8'(b ^ 8'ha3); imm_i = 8'(b ^ 8'h3c);
    case (sel)
      1: mem_i = b[7:0];
      2: imm_i = b[7:0];
      default: reg_i = b[7:0];
    endcase
    e = model(op, a, b, c);
    @(negedge clk);
    chk({tag, " result"}, res_o, e[17:10]);
    chk({tag, " carry"}, flags_o[0], e[5]);
    chk("R5 aux", flags_o[2], e[7]);
    chk("R6 S/Z/P", {flags_o[4:3], flags_o[1]}, {e[9:8], e[6]});
    chk(op < 4 ? "R8 mask" : (op < 6 ? "R7 mask" : "R10 mask"), upd_o, e[4:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", res_o, 0);
    chk("R1 reset flags", flags_o, 5'b01010);
    chk("R1 reset mask", upd_o, 0);
    rst = 1'b0;

    // R2: inputs changed between edges stay invisible until the next edge
    vec(0, 0, 8'h12, 8'h34, 0, "R3");
    op_i = 3'd2; acc_i = 8'h00; reg_i = 8'h01;
    #1;
    chk("R2 held result", res_o, 8'h46);
    @(negedge clk);
    chk("R2 next result", res_o, 8'hff);

    // R3 add with carry, all accumulators, both carries
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 2)
        for (int c = 0; c < 2; c++) vec(1, 0, a, b, c, "R3 adc");
    // R4 subtract with borrow
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 3)
        for (int c = 0; c < 2; c++) vec(3, 1, a, b, c, "R4 sbb");
    // plain add / subtract: carry-in must not matter
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 5) begin
        vec(0, 2, a, b, b % 2, "R3 add");
        vec(2, 0, a, b, (b + 1) % 2, "R4 sub");
      end
    // R7 increment / decrement over every operand, every source
    for (int b = 0; b < 256; b++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 2; c++) begin
          vec(4, s, b ^ 8'h77, b, c, "R7 inc");
          vec(5, s, b ^ 8'h77, b, c, "R7 dec");
        end
    // R9 each source, including code 3 mapping to register
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 256; b += 17) vec(0, s, 8'h21, b, 0, "R9 source");
    // R10 reserved codes
    for (int a = 0; a < 256; a++) begin
      vec(6, 0, a, 255 - a, a % 2, "R10 rsv6");
      vec(7, 1, a, a, (a + 1) % 2, "R10 rsv7");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule